// File: doc/BRIEF.md
# Transmit Byte Counter with Automatic End-of-Packet Marking

This block sits in the byte path between a processor's write port and a transmit FIFO that feeds an HDLC framer. Software programs an 8-bit packet length. The block then counts the bytes written toward the FIFO. When the counter reaches the last byte of the packet, it replaces the byte's 2-bit tag with the end-of-packet code, so software does not have to mark packet boundaries byte by byte. An optional cycle mode reloads the programmed length after each end-of-packet byte. Back-to-back packets of the same size then need no further register writes.

The byte path is a valid/ready stream that passes through without storage. `out_valid` follows `in_valid`, `in_ready` follows `out_ready`, and data passes straight through. A byte counts only on a beat where `in_valid` and `out_ready` are both high. When the FIFO side holds `out_ready` low, the producer must keep its byte and tag steady, and the counter does not move. The length register, the working count and the cycle-mode pin are plain control signals. All flops reset synchronously.

Top module: `eopt_tagger`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears both the working count and the stored length to 0.
- R2: A cycle with `cfg_wr_en` high loads `cfg_wr_data` into both the working count and the stored length at that edge. This load overrides any decrement or reload from a byte transferred in the same cycle.
- R3: A transfer is a cycle with `in_valid` and `out_ready` both high. A transfer with the count above 1 lowers the count by exactly 1 at the end of that cycle. A cycle with no transfer and no register write leaves the count unchanged.
- R4: While the count equals 1, `out_tag` is the end-of-packet code 2'b01 whatever `in_tag` carries, including the abort code 2'b10. The normal-byte code is 2'b00.
- R5: With `cycle_en` low, the transfer made while the count is 1 leaves the count at 0. The count then stays at 0 and no further tags are forced.
- R6: With `cycle_en` high, the transfer made while the count is 1 reloads the count from the stored length.
- R7: While the count is 0, `out_tag` equals `in_tag` unaltered, so software can supply its own end-of-packet or abort codes.
- R8: `out_valid` equals `in_valid`, `in_ready` equals `out_ready`, and `out_data` equals `in_data` in the same cycle. A beat stalled by a low `out_ready` does not count.
- R9: `cnt_rd` shows the working count and `len_rd` shows the stored length at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_wr_en | input | 1 | Length register write strobe |
| cfg_wr_data | input | 8 | Packet length to load |
| cycle_en | input | 1 | Reload the length after each end-of-packet byte |
| in_valid | input | 1 | Producer byte valid |
| in_ready | output | 1 | Block ready for the producer byte |
| in_data | input | 8 | Producer byte |
| in_tag | input | 2 | Producer tag: 00 normal, 01 end-of-packet, 10 abort |
| out_valid | output | 1 | Byte valid toward the FIFO |
| out_ready | input | 1 | FIFO can accept the byte |
| out_data | output | 8 | Byte toward the FIFO |
| out_tag | output | 2 | Tag toward the FIFO, possibly forced to end-of-packet |
| cnt_rd | output | 8 | Working count readback |
| len_rd | output | 8 | Stored length readback |

## Verification
The assertions check the following on every cycle:
- a register write loads both the count and the length;
- the count steps down by one per transfer;
- the count holds when there is no transfer;
- the reload or the stop at zero after an end-of-packet byte;
- the forcing of the tag at a count of one;
- the stream handshake wiring.

Only the bench scenarios show complete packets in sequence: a fixed-length packet followed by manual tagging at zero, repeated packets in cycle mode with stalls inside them, an abort overridden on the last byte, a register write colliding with a transfer, and a reset in the middle of a packet.

// File: rtl/eopt_pkg.sv
package eopt_pkg;

  // Tag code carried beside each FIFO byte
  typedef enum logic [1:0] {
    TAG_DATA  = 2'b00,
    TAG_EOP   = 2'b01,
    TAG_ABORT = 2'b10,
    TAG_RSVD  = 2'b11
  } tag_e;

  localparam int TAG_W = 2;

  // What the counter does on an accepted byte
  typedef enum logic [1:0] {
    STEP_HOLD   = 2'b00,
    STEP_DEC    = 2'b01,
    STEP_RELOAD = 2'b10,
    STEP_STOP   = 2'b11
  } step_e;

endpackage

// File: rtl/eopt_step_dec.sv
module eopt_step_dec
  import eopt_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic [CNT_W-1:0] cnt,
  input  logic             beat,
  input  logic             cycle_en,
  output step_e            step,
  output logic             at_last
);

  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] ZERO = '0;

  always_comb begin
    at_last = (cnt == ONE);
    step    = STEP_HOLD;
    if (beat) begin
      if (cnt == ZERO)     step = STEP_HOLD;
      else if (at_last)    step = cycle_en ? STEP_RELOAD : STEP_STOP;
      else                 step = STEP_DEC;
    end
  end

endmodule

// File: rtl/eopt_len_counter.sv
module eopt_len_counter
  import eopt_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_en,
  input  logic [CNT_W-1:0] load_val,
  input  step_e            step,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] len
);

  logic [CNT_W-1:0] cnt_nxt;

  always_comb begin
    cnt_nxt = cnt;
    unique case (step)
      STEP_DEC:    cnt_nxt = cnt - CNT_W'(1);
      STEP_RELOAD: cnt_nxt = len;
      STEP_STOP:   cnt_nxt = '0;
      default:     cnt_nxt = cnt;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      len <= '0;
    end else if (load_en) begin
      cnt <= load_val;
      len <= load_val;
    end else begin
      cnt <= cnt_nxt;
    end
  end

endmodule

// File: rtl/eopt_tag_mux.sv
module eopt_tag_mux
  import eopt_pkg::*;
(
  input  logic [TAG_W-1:0] tag_in,
  input  logic             force_eop,
  output logic [TAG_W-1:0] tag_out
);

  always_comb begin
    if (force_eop) tag_out = TAG_EOP;
    else           tag_out = tag_in;
  end

endmodule

// File: rtl/eopt_tagger.sv
module eopt_tagger
  import eopt_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr_en,
  input  logic [CNT_W-1:0]  cfg_wr_data,
  input  logic              cycle_en,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic [1:0]        in_tag,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic [1:0]        out_tag,
  output logic [CNT_W-1:0]  cnt_rd,
  output logic [CNT_W-1:0]  len_rd
);

  logic             beat;
  logic             at_last;
  step_e            step;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] len;

  // Stream passes through without storage
  assign out_valid = in_valid;
  assign in_ready  = out_ready;
  assign out_data  = in_data;
  assign beat      = in_valid && out_ready;

  eopt_step_dec #(.CNT_W(CNT_W)) u_step (
    .cnt      (cnt),
    .beat     (beat),
    .cycle_en (cycle_en),
    .step     (step),
    .at_last  (at_last)
  );

  eopt_len_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .load_en  (cfg_wr_en),
    .load_val (cfg_wr_data),
    .step     (step),
    .cnt      (cnt),
    .len      (len)
  );

  eopt_tag_mux u_tag (
    .tag_in    (in_tag),
    .force_eop (at_last),
    .tag_out   (out_tag)
  );

  assign cnt_rd = cnt;
  assign len_rd = len;

endmodule

// File: rtl/eopt_tagger_chk.sv
module eopt_tagger_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_wr_en,
  input logic [CNT_W-1:0] cfg_wr_data,
  input logic             cycle_en,
  input logic             in_valid,
  input logic             in_ready,
  input logic [1:0]       in_tag,
  input logic             out_valid,
  input logic             out_ready,
  input logic [1:0]       out_tag,
  input logic [CNT_W-1:0] cnt_rd,
  input logic [CNT_W-1:0] len_rd
);

  logic xfer;
  assign xfer = in_valid && in_ready;

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (cnt_rd == '0 && len_rd == '0));

  assert_cfg_load_R2: assert property (@(posedge clk) disable iff (rst)
    cfg_wr_en |=> (cnt_rd == $past(cfg_wr_data) && len_rd == $past(cfg_wr_data)));

  assert_dec_R3: assert property (@(posedge clk) disable iff (rst)
    (xfer && !cfg_wr_en && cnt_rd > CNT_W'(1)) |=> cnt_rd == $past(cnt_rd) - CNT_W'(1));

  assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!xfer && !cfg_wr_en) |=> $stable(cnt_rd) && $stable(len_rd));

  assert_force_eop_R4: assert property (@(posedge clk) disable iff (rst)
    (cnt_rd == CNT_W'(1)) |-> out_tag == 2'b01);

  assert_stop_R5: assert property (@(posedge clk) disable iff (rst)
    (xfer && !cfg_wr_en && !cycle_en && cnt_rd == CNT_W'(1)) |=> cnt_rd == '0);

  assert_reload_R6: assert property (@(posedge clk) disable iff (rst)
    (xfer && !cfg_wr_en && cycle_en && cnt_rd == CNT_W'(1)) |=> cnt_rd == $past(len_rd));

  assert_pass_tag_R7: assert property (@(posedge clk) disable iff (rst)
    (cnt_rd == '0) |-> out_tag == in_tag);

  assert_handshake_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid == in_valid) && (in_ready == out_ready));

endmodule

bind eopt_tagger eopt_tagger_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cfg_wr_en   (cfg_wr_en),
  .cfg_wr_data (cfg_wr_data),
  .cycle_en    (cycle_en),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .in_tag      (in_tag),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_tag     (out_tag),
  .cnt_rd      (cnt_rd),
  .len_rd      (len_rd)
);

// File: tb/eopt_tagger_bench.sv
module eopt_tagger_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_wr_en = 1'b0;
  logic [7:0] cfg_wr_data = '0;
  logic       cycle_en = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = '0;
  logic [1:0] in_tag = '0;
  logic       out_valid;
  logic       out_ready = 1'b0;
  logic [7:0] out_data;
  logic [1:0] out_tag;
  logic [7:0] cnt_rd;
  logic [7:0] len_rd;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  eopt_tagger u_eopt_tagger (
    .clk(clk), .rst(rst), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
    .cycle_en(cycle_en), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_tag(in_tag), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_tag(out_tag),
    .cnt_rd(cnt_rd), .len_rd(len_rd)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // {cfg_we, cfg_val[8], cycle, vld, rdy, tag[2], exp_tag[2], exp_cnt[8]}
  localparam int NV = 19;
  localparam logic [23:0] VEC [NV] = '{
    {1'b1, 8'd3, 1'b0, 1'b0, 1'b0, 2'b00, 2'b00, 8'd3},
    {1'b0, 8'd0, 1'b0, 1'b1, 1'b1, 2'b00, 2'b00, 8'd2},
    {1'b0, 8'd0, 1'b0, 1'b1, 1'b1, 2'b00, 2'b00, 8'd1},
    {1'b0, 8'd0, 1'b0, 1'b1, 1'b1, 2'b00, 2'b01, 8'd0},
    {1'b0, 8'd0, 1'b0, 1'b1, 1'b1, 2'b00, 2'b00, 8'd0},
    {1'b0, 8'd0, 1'b0, 1'b1, 1'b1, 2'b01, 2'b01, 8'd0},
    {1'b1, 8'd2, 1'b1, 1'b0, 1'b0, 2'b00, 2'b00, 8'd2},
    {1'b0, 8'd0, 1'b1, 1'b1, 1'b1, 2'b00, 2'b00, 8'd1},
    {1'b0, 8'd0, 1'b1, 1'b1, 1'b0, 2'b00, 2'b01, 8'd1},
    {1'b0, 8'd0, 1'b1, 1'b1, 1'b1, 2'b00, 2'b01, 8'd2},
    {1'b0, 8'd0, 1'b1, 1'b1, 1'b1, 2'b00, 2'b00, 8'd1},
    {1'b0, 8'd0, 1'b1, 1'b1, 1'b1, 2'b00, 2'b01, 8'd2},
    {1'b0, 8'd0, 1'b1, 1'b0, 1'b1, 2'b00, 2'b00, 8'd2},
    {1'b0, 8'd0, 1'b1, 1'b1, 1'b1, 2'b10, 2'b10, 8'd1},
    {1'b0, 8'd0, 1'b1, 1'b1, 1'b1, 2'b10, 2'b01, 8'd2},
    {1'b1, 8'd5, 1'b1, 1'b1, 1'b1, 2'b00, 2'b00, 8'd5},
    {1'b1, 8'd1, 1'b0, 1'b0, 1'b0, 2'b00, 2'b00, 8'd1},
    {1'b0, 8'd0, 1'b0, 1'b1, 1'b1, 2'b00, 2'b01, 8'd0},
    {1'b1, 8'd0, 1'b0, 1'b1, 1'b1, 2'b00, 2'b00, 8'd0}
  };

  // Drive on the falling edge, check the tag just after, check the count after the rising edge
  task automatic step(input logic we, input logic [7:0] val, input logic cyc,
                      input logic vld, input logic rdy, input logic [1:0] tag,
                      input logic [7:0] dat);
    @(negedge clk);
    cfg_wr_en = we; cfg_wr_data = val; cycle_en = cyc;
    in_valid = vld; out_ready = rdy; in_tag = tag; in_data = dat;
    #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset count", cnt_rd, 0);
    chk("R1 reset length", len_rd, 0);
    @(negedge clk); rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][23], VEC[i][22:15], VEC[i][14], VEC[i][13], VEC[i][12],
           VEC[i][11:10], 8'(i + 8'h40));
      chk($sformatf("R4/R7 tag vec %0d", i), out_tag, VEC[i][9:8]);
      chk($sformatf("R8 data vec %0d", i), out_data, i + 'h40);
      @(posedge clk); #1;
      chk($sformatf("R2/R3/R5/R6 count vec %0d", i), cnt_rd, VEC[i][7:0]);
    end
    chk("R9 length readback", len_rd, 0);

    // R8: handshake wiring under stall
    step(1'b0, 8'd0, 1'b0, 1'b1, 1'b0, 2'b00, 8'h11);
    chk("R8 in_ready low", in_ready, 0);
    chk("R8 out_valid high", out_valid, 1);
    step(1'b0, 8'd0, 1'b0, 1'b0, 1'b1, 2'b00, 8'h11);
    chk("R8 in_ready high", in_ready, 1);
    chk("R8 out_valid low", out_valid, 0);

    // R3: maximum length, one byte
    step(1'b1, 8'd255, 1'b1, 1'b0, 1'b0, 2'b00, 8'h00);
    @(posedge clk); #1;
    chk("R9 length 255", len_rd, 255);
    step(1'b0, 8'd0, 1'b1, 1'b1, 1'b1, 2'b00, 8'h00);
    chk("R4 no force at 255", out_tag, 0);
    @(posedge clk); #1;
    chk("R3 count 254", cnt_rd, 254);
    chk("R9 length kept", len_rd, 255);

    // R1: reset in the middle of a packet
    step(1'b0, 8'd0, 1'b1, 1'b0, 1'b0, 2'b00, 8'h00);
    rst = 1'b1;
    @(posedge clk); #1;
    chk("R1 mid-packet count", cnt_rd, 0);
    chk("R1 mid-packet length", len_rd, 0);
    @(negedge clk); rst = 1'b0;
    step(1'b0, 8'd0, 1'b0, 1'b1, 1'b1, 2'b10, 8'h00);
    chk("R7 abort passes at zero", out_tag, 2);
    @(posedge clk); #1;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule